// File: doc/BRIEF.md
# Long-Division Multiply-Subtract Step

This block carries out the vector part of one radix-2^W long-division step. A quotient digit estimate `q` arrives from outside, together with an N-limb divisor V and an (N+1)-limb window U of the partial remainder. The block forms U − q·V one limb per cycle, least significant limb first. Each limb uses a multiply-subtract of the form C − A·B on a full double-width product. The low half of each intermediate becomes the result limb, and the high half is turned into a borrow for the next limb. The product q·V has no limb at index N, so the top window limb only absorbs the last borrow.

A nonzero borrow after limb N means the window went negative, because the estimate was one too large. In that case the block adds V back once with a carry-propagating add, and it decrements the digit. It never applies more than one add-back per step. The corrected window, the corrected digit and a flag that reports whether the add-back ran are all held after completion.

The controller has four states:
- **IDLE**: waits for `start`.
- **MSUB**: handles one limb per cycle.
- **ADDB**: handles one limb per cycle.
- **DONE**: lasts a single cycle.

The transitions are:
- IDLE→MSUB on `start`.
- MSUB→MSUB while the limb index is below N.
- MSUB→DONE on limb N when no borrow is left.
- MSUB→ADDB on limb N when a borrow is left.
- ADDB→ADDB while the limb index is below N.
- ADDB→DONE on limb N.
- DONE→IDLE unconditionally.

Top module: `ldiv_msub_step`

## Requirements
- R1: After reset, `busy`, `done` and `corrected` are 0, and `q_out` and `remainder` are all zeros.
- R2: A `start` pulse seen in IDLE captures `n_limbs`, `q_est`, `divisor` and `window`. On the following cycle `busy` is 1.
- R3: If U − q·V ≥ 0, the final `remainder` limbs 0..N hold U − q·V, `corrected` is 0 and `q_out` equals `q_est`. Limb i sits at bits [i·W +: W] of `window`, `divisor` and `remainder`.
- R4: If U − q·V < 0, detected as a nonzero borrow after limb N, V is added back once. `remainder` limbs 0..N then hold (U − q·V + V) mod 2^((N+1)·W), `corrected` is 1 and `q_out` is (q_est − 1) mod 2^W.
- R5: Exactly one add-back is done even when the estimate is too large by more than one. The result is then (U − q·V + V) mod 2^((N+1)·W).
- R6: `window` limbs above index N appear unchanged in `remainder`. `divisor` limbs at index N and above do not affect the result.
- R7: `done` is seen N+2 cycles after the edge that samples `start` with no correction, and 2N+3 cycles after it with a correction. The count includes that edge.
- R8: `start` while `busy` is 1 is ignored, and the running step finishes with its original operands.
- R9: `done` is high for one cycle only. The cycle after it, `busy` is 0 and the outputs keep their values.
- R10: With `q_est` = 0 the result equals U, and `corrected` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one step (taken only in IDLE) |
| n_limbs | input | IDX_W | Divisor limb count N, 1..MAX_LIMBS |
| q_est | input | LIMB_W | Quotient digit estimate |
| divisor | input | MAX_LIMBS·LIMB_W | Divisor limbs, limb 0 lowest |
| window | input | (MAX_LIMBS+1)·LIMB_W | Partial-remainder window limbs |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| corrected | output | 1 | Add-back was applied |
| q_out | output | LIMB_W | Corrected digit |
| remainder | output | (MAX_LIMBS+1)·LIMB_W | Corrected window |

## Verification
With 4-bit limbs and one divisor limb, every estimate is crossed with every divisor digit and several window pairs. This separates exact estimates, estimates that are one too large, estimates that are far too large, and the q = 0 and V = 0 edges. Pseudo-random two- and three-limb operands, with junk in the unused limbs, show that the borrow travels across many limbs and that the unused inputs are ignored. The expected digit, window, flag and latency are computed from plain integer arithmetic. A restart attempted mid-step shows whether the original operands survive.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MSUB,
        ST_ADDB,
        ST_DONE
    } ldiv_state_e;
endpackage

// File: rtl/ldiv_msub_limb.sv
// One limb of the chained multiply-subtract: u - q*v - borrow_in.
module ldiv_msub_limb #(
    parameter int LIMB_W = 64
) (
    input  logic [LIMB_W-1:0] u_limb,
    input  logic [LIMB_W-1:0] v_limb,
    input  logic [LIMB_W-1:0] q_digit,
    input  logic [LIMB_W:0]   borrow_in,
    output logic [LIMB_W-1:0] diff_limb,
    output logic [LIMB_W:0]   borrow_out
);
    localparam int AW = 2 * LIMB_W + 2;

    logic [2*LIMB_W-1:0] prod;
    logic [AW-1:0]       acc;
    logic [LIMB_W+1:0]   hi;

    always_comb begin
        prod       = {{LIMB_W{1'b0}}, q_digit} * {{LIMB_W{1'b0}}, v_limb};
        acc        = {{(LIMB_W+2){1'b0}}, u_limb} - {2'b00, prod}
                   - {{(LIMB_W+1){1'b0}}, borrow_in};
        diff_limb  = acc[LIMB_W-1:0];
        hi         = acc[AW-1:LIMB_W];
        // high half is zero or negative; its magnitude is the next borrow
        borrow_out = (LIMB_W+1)'(-hi);
    end
endmodule

// File: rtl/ldiv_addback_limb.sv
// One limb of the correction add: r + v + carry_in.
module ldiv_addback_limb #(
    parameter int LIMB_W = 64
) (
    input  logic [LIMB_W-1:0] r_limb,
    input  logic [LIMB_W-1:0] v_limb,
    input  logic              carry_in,
    output logic [LIMB_W-1:0] sum_limb,
    output logic              carry_out
);
    logic [LIMB_W:0] sum;

    always_comb begin
        sum       = {1'b0, r_limb} + {1'b0, v_limb} + {{LIMB_W{1'b0}}, carry_in};
        sum_limb  = sum[LIMB_W-1:0];
        carry_out = sum[LIMB_W];
    end
endmodule

// File: rtl/ldiv_msub_step.sv
module ldiv_msub_step
    import ldiv_pkg::*;
#(
    parameter int LIMB_W    = 64,
    parameter int MAX_LIMBS = 4,
    localparam int WIN      = MAX_LIMBS + 1,
    localparam int IDX_W    = $clog2(MAX_LIMBS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [IDX_W-1:0]          n_limbs,
    input  logic [LIMB_W-1:0]         q_est,
    input  logic [MAX_LIMBS*LIMB_W-1:0] divisor,
    input  logic [WIN*LIMB_W-1:0]     window,
    output logic                      busy,
    output logic                      done,
    output logic                      corrected,
    output logic [LIMB_W-1:0]         q_out,
    output logic [WIN*LIMB_W-1:0]     remainder
);
    ldiv_state_e state, nxt;

    logic [IDX_W-1:0]  idx, n_reg;
    logic [LIMB_W-1:0] q_reg;
    logic [LIMB_W-1:0] v_reg [MAX_LIMBS];
    logic [LIMB_W-1:0] r_reg [WIN];
    logic [LIMB_W:0]   borrow_reg;
    logic              carry_reg;
    logic              corr_reg;

    logic [LIMB_W-1:0] v_cur, r_cur;
    logic [LIMB_W-1:0] diff_limb, sum_limb;
    logic [LIMB_W:0]   borrow_nxt;
    logic              carry_nxt;
    logic              last;

    // limb selection: divisor limbs at index >= N read as zero
    always_comb begin
        v_cur = '0;
        r_cur = '0;
        for (int k = 0; k < MAX_LIMBS; k++)
            if (idx == IDX_W'(k) && IDX_W'(k) < n_reg)
                v_cur = v_reg[k];
        for (int k = 0; k < WIN; k++)
            if (idx == IDX_W'(k))
                r_cur = r_reg[k];
    end

    assign last = (idx == n_reg);

    ldiv_msub_limb #(.LIMB_W(LIMB_W)) i_msub (
        .u_limb    (r_cur),
        .v_limb    (v_cur),
        .q_digit   (q_reg),
        .borrow_in (borrow_reg),
        .diff_limb (diff_limb),
        .borrow_out(borrow_nxt)
    );

    ldiv_addback_limb #(.LIMB_W(LIMB_W)) i_addb (
        .r_limb   (r_cur),
        .v_limb   (v_cur),
        .carry_in (carry_reg),
        .sum_limb (sum_limb),
        .carry_out(carry_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_MSUB;
            ST_MSUB: if (last)  nxt = (borrow_nxt != '0) ? ST_ADDB : ST_DONE;
            ST_ADDB: if (last)  nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            n_reg      <= '0;
            q_reg      <= '0;
            borrow_reg <= '0;
            carry_reg  <= 1'b0;
            corr_reg   <= 1'b0;
            for (int k = 0; k < MAX_LIMBS; k++) v_reg[k] <= '0;
            for (int k = 0; k < WIN; k++)       r_reg[k] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    idx        <= '0;
                    n_reg      <= n_limbs;
                    q_reg      <= q_est;
                    borrow_reg <= '0;
                    carry_reg  <= 1'b0;
                    corr_reg   <= 1'b0;
                    for (int k = 0; k < MAX_LIMBS; k++)
                        v_reg[k] <= divisor[k*LIMB_W +: LIMB_W];
                    for (int k = 0; k < WIN; k++)
                        r_reg[k] <= window[k*LIMB_W +: LIMB_W];
                end
                ST_MSUB: begin
                    for (int k = 0; k < WIN; k++)
                        if (idx == IDX_W'(k)) r_reg[k] <= diff_limb;
                    borrow_reg <= borrow_nxt;
                    idx        <= last ? '0 : idx + IDX_W'(1);
                    if (last && borrow_nxt != '0) begin
                        corr_reg <= 1'b1;
                        q_reg    <= q_reg - LIMB_W'(1);
                    end
                end
                ST_ADDB: begin
                    for (int k = 0; k < WIN; k++)
                        if (idx == IDX_W'(k)) r_reg[k] <= sum_limb;
                    carry_reg <= carry_nxt;
                    idx       <= last ? '0 : idx + IDX_W'(1);
                end
                ST_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        corrected = corr_reg;
        q_out     = q_reg;
        for (int k = 0; k < WIN; k++)
            remainder[k*LIMB_W +: LIMB_W] = r_reg[k];
    end

    // ---------------- assertions ----------------
    assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (idx <= n_reg));

    assert_addback_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDB) |-> corr_reg);

    assert_digit_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corr_reg) |-> (q_reg == $past(q_reg) - LIMB_W'(1)));

    assert_single_addback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDB && last) |=> (state == ST_DONE));

    assert_busy_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MSUB && !last) |=> (idx == $past(idx) + IDX_W'(1)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/test_ldiv_msub_step.sv
`timescale 1ns/1ps
module test_ldiv_msub_step;
    localparam int W   = 4;
    localparam int MX  = 3;
    localparam int WIN = MX + 1;
    localparam int IW  = $clog2(MX + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IW-1:0]     n_limbs = '0;
    logic [W-1:0]      q_est = '0;
    logic [MX*W-1:0]   divisor = '0;
    logic [WIN*W-1:0]  window = '0;
    logic              busy, done, corrected;
    logic [W-1:0]      q_out;
    logic [WIN*W-1:0]  remainder;

    int errors = 0;
    int checks = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    ldiv_msub_step #(.LIMB_W(W), .MAX_LIMBS(MX)) i_ldiv_msub_step (
        .clk, .rst_n, .start, .n_limbs, .q_est, .divisor, .window,
        .busy, .done, .corrected, .q_out, .remainder
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // expects to be called at a negedge
    task automatic do_op(input int n, input logic [W-1:0] q,
                         input logic [MX*W-1:0] vf, input logic [WIN*W-1:0] uf,
                         input string base_tag);
        longint umask, vmask, uval, vval, diff, res, rexp;
        logic [W-1:0] qx;
        bit neg;
        int cycles;
        string tag;
        logic [WIN*W-1:0] held;
        umask = (longint'(1) << ((n + 1) * W)) - 1;
        vmask = (longint'(1) << (n * W)) - 1;
        uval  = longint'(uf) & umask;
        vval  = longint'(vf) & vmask;
        diff  = uval - longint'(q) * vval;
        neg   = diff < 0;
        res   = neg ? diff + vval : diff;
        qx    = neg ? q - 4'd1 : q;
        rexp  = (longint'(uf) & ~umask) | (res & umask);
        if (q == 0)              tag = "R10";
        else if (neg && res < 0) tag = "R5";
        else if (neg)            tag = "R4";
        else                     tag = base_tag;

        n_limbs = IW'(n); q_est = q; divisor = vf; window = uf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        chk(busy == 1'b1, "R2", longint'(busy), 1);
        while (!done && cycles < 60) begin
            @(negedge clk);
            cycles++;
        end
        if (!done) chk(1'b0, "R7 watchdog", cycles, 0);
        chk(cycles == (neg ? 2*n + 3 : n + 2), "R7", cycles, neg ? 2*n + 3 : n + 2);
        chk(longint'(remainder) == rexp, tag, longint'(remainder), rexp);
        chk(q_out == qx, neg ? "R4" : "R3", longint'(q_out), longint'(qx));
        chk(corrected == neg, neg ? "R4" : "R3", longint'(corrected), longint'(neg));
        held = remainder;
        @(negedge clk);
        chk(!done && !busy && remainder == held, "R9",
            longint'({done, busy}), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !corrected, "R1", longint'({busy, done, corrected}), 0);
        chk(q_out == '0 && remainder == '0, "R1", longint'(remainder), 0);

        // R3/R4/R5/R10: every digit and single-limb divisor, several windows
        for (int q = 0; q < 16; q++)
            for (int v = 0; v < 16; v++)
                for (int k = 0; k < 8; k++) begin
                    logic [WIN*W-1:0] uf;
                    logic [MX*W-1:0]  vf;
                    uf = {8'hA5, 8'((k * 37 + v * 5 + 3) & 8'hFF)};
                    vf = {8'h3C, 4'(v)};
                    do_op(1, 4'(q), vf, uf, "R3");
                end

        // R6: two limbs, junk in unused divisor and window limbs
        for (int t = 0; t < 1500; t++) begin
            logic [31:0] a, b;
            a = rnd(); b = rnd();
            do_op(2, b[19:16], a[27:16], b[31:16], "R6");
        end

        // full width: three limbs
        for (int t = 0; t < 600; t++) begin
            logic [31:0] a, b;
            a = rnd(); b = rnd();
            do_op(3, a[31:28], b[27:16], {a[15:12], b[31:28], a[23:16]}, "R3");
        end

        // R8: restart attempt while busy is ignored
        begin
            logic [WIN*W-1:0] exp_r;
            n_limbs = IW'(2); q_est = 4'd2; divisor = 12'h0_21; window = 16'h0_100;
            start = 1'b1;
            @(negedge clk);
            start = 1'b1; q_est = 4'd9; window = 16'hFFFF; divisor = 12'hFFF;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 60 && !done; c++) @(negedge clk);
            // 0x100 - 2*0x21 = 0xBE, no correction
            exp_r = 16'h00BE;
            chk(remainder == exp_r, "R8", longint'(remainder), longint'(exp_r));
            chk(q_out == 4'd2 && !corrected, "R8", longint'(q_out), 2);
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule